// File: doc/BRIEF.md
# Power-State Access Gate for a PCI Bridge

This block holds the power-management capability registers of a PCI bridge and decides, per transaction, whether the bridge may claim an incoming access or start one of its own. Configuration software reads the capability header and the control/status register through a small dword-indexed window. It moves the device between power states by writing the two-bit state field of that register.

Each transaction is presented with a one-cycle start strobe. The strobe comes with the access kind (memory, I/O, configuration or reserved) and a flag that marks a request from the bridge's own master side. The block registers a claim, master-grant and abort decision at that strobe and holds it until the next strobe.

Outside the fully-on state, memory and I/O target accesses and all mastering are blocked, whatever the command-register enables say. Configuration accesses are claimed in every state. Removal of power (the deepest off state) is modelled by the reset input, which returns the device to the fully-on state.

Top module: `pm_access_gate`

## Requirements
- R1: Window dword 0 reads {capabilities word 0x0202 in bits [31:16], next-capability pointer (default 0x50) in bits [15:8], capability ID 0x01 in bits [7:0]}, so with defaults 0x0202_5001.
- R2: Window dword 1 reads the power state in bits [1:0] with all other bits zero, so the bridge-extension byte [23:16] and the data byte [31:24] are 0x00. Dwords 2 and 3 read zero. Read data is combinational from the address.
- R3: A write to dword 1 whose bits [1:0] encode D0=00, D1=01 or D3hot=11 sets the state, and the new state is readable in the cycle after the write.
- R4: A write to dword 1 whose bits [1:0] are 10 (D2, unsupported) is ignored and the previous state is kept.
- R5: Writes to dwords 0, 2 and 3 change neither any register value nor the power state.
- R6: Reset (also the model of power removal from D3hot) sets the state to D0 and drives tgt_claim, mst_allow and txn_abort to 0.
- R7: In D0, a target access of kind memory (00) or I/O (01) is claimed only if command-enable bit 0 or bit 1 respectively is set. A master request is allowed only if command-enable bit 2 is set.
- R8: In any state other than D0, memory and I/O target accesses are not claimed and master requests are not allowed, even with all command-enable bits set.
- R9: A configuration target access (kind 10) is claimed in every power state, regardless of the command enables. A master request never asserts tgt_claim.
- R10: txn_abort is 1 exactly when the latest transaction was a target access that was not claimed. Kind 11 is reserved and is never claimed.
- R11: Decisions are captured at the clock edge where txn_start is 1 and held until the next start. A state write in the same cycle as a start affects only later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also models power removal |
| cfg_req | input | 1 | Configuration access to the capability window this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | AW (2) | Dword index inside the capability window |
| cfg_wdata | input | DW (32) | Write data |
| cfg_rdata | output | DW (32) | Read data for cfg_addr |
| cmd_en | input | 3 | Command enables: bit 0 memory, bit 1 I/O, bit 2 bus master |
| txn_start | input | 1 | Start strobe of a new transaction |
| txn_kind | input | 2 | 00 memory, 01 I/O, 10 configuration, 11 reserved |
| txn_master | input | 1 | 1 = request from the bridge's own master side |
| tgt_claim | output | 1 | Bridge claims the current target access |
| mst_allow | output | 1 | Bridge may start the current master request |
| txn_abort | output | 1 | Unclaimed target access, ends in master abort |

## Verification
The hardest case to reach is the race between a state write and a transaction start on the same clock edge. Both must land on one edge, and only the following transaction may see the new state. The bench drives the start strobe and the configuration write in the same cycle and checks that the captured decision reflects the old state. It then checks that the next start reflects the new state, and that later state writes leave the held decision alone. Every state is also reached and then poked with a D2 request, and the bench sweeps every kind, master flag and command-enable combination in each supported state.

// File: rtl/pm_gate_pkg.sv
package pm_gate_pkg;
   typedef enum logic [1:0] {
      PS_D0  = 2'b00,
      PS_D1  = 2'b01,
      PS_D2  = 2'b10,
      PS_D3H = 2'b11
   } pstate_e;

   typedef enum logic [1:0] {
      TK_MEM = 2'b00,
      TK_IO  = 2'b01,
      TK_CFG = 2'b10,
      TK_RSV = 2'b11
   } tkind_e;

   localparam int unsigned CMD_MEM = 0;
   localparam int unsigned CMD_IO  = 1;
   localparam int unsigned CMD_BM  = 2;

   localparam logic [7:0] PM_CAP_ID = 8'h01;
endpackage

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
   import pm_gate_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 2,
   parameter logic [7:0]  NEXT_PTR = 8'h50,
   parameter logic [15:0] PMC_VAL  = 16'h0202,
   parameter bit          ALLOW_D2 = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_req,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   output pstate_e       pm_state
);
   localparam logic [AW-1:0] HDR_IDX  = AW'(0);
   localparam logic [AW-1:0] CTRL_IDX = AW'(1);

   if (DW != 32) begin : g_bad_dw
      $error("pm_cap_regs: DW must be 32");
   end
   if (AW < 1) begin : g_bad_aw
      $error("pm_cap_regs: AW must be at least 1");
   end
   if (NEXT_PTR[1:0] != 2'b00) begin : g_bad_ptr
      $error("pm_cap_regs: NEXT_PTR must be dword aligned");
   end

   logic       wr_ctrl;
   logic [1:0] req_code;
   logic       accept;

   assign wr_ctrl  = cfg_req && cfg_we && (cfg_addr == CTRL_IDX);
   assign req_code = cfg_wdata[1:0];

   if (ALLOW_D2) begin : g_d2_on
      assign accept = 1'b1;
   end else begin : g_d2_off
      assign accept = (req_code != PS_D2);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pm_state <= PS_D0;
      end else if (wr_ctrl && accept) begin
         pm_state <= pstate_e'(req_code);
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == HDR_IDX) begin
         cfg_rdata = {PMC_VAL, NEXT_PTR, PM_CAP_ID};
      end else if (cfg_addr == CTRL_IDX) begin
         cfg_rdata = {8'h00, 8'h00, 14'd0, pm_state};
      end
   end

   AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && accept) |=> (pm_state == $past(cfg_wdata[1:0]))); // R3

   AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_we && cfg_addr != CTRL_IDX) |=> $stable(pm_state)); // R5

   if (!ALLOW_D2) begin : g_d2_chk
      AST_D2_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl && cfg_wdata[1:0] == 2'b10) |=> $stable(pm_state)); // R4
   end
endmodule

// File: rtl/pm_claim_decide.sv
module pm_claim_decide
   import pm_gate_pkg::*;
#(
   parameter int unsigned CMD_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pstate_e          pm_state,
   input  logic [CMD_W-1:0] cmd_en,
   input  logic             txn_start,
   input  logic [1:0]       txn_kind,
   input  logic             txn_master,
   output logic             tgt_claim,
   output logic             mst_allow,
   output logic             txn_abort
);
   if (CMD_W != 3) begin : g_bad_cmd
      $error("pm_claim_decide: CMD_W must be 3");
   end

   logic awake;
   logic claim_n, allow_n, abort_n;

   assign awake = (pm_state == PS_D0);

   always_comb begin
      claim_n = 1'b0;
      if (!txn_master) begin
         case (txn_kind)
            TK_MEM:  claim_n = awake && cmd_en[CMD_MEM];
            TK_IO:   claim_n = awake && cmd_en[CMD_IO];
            TK_CFG:  claim_n = 1'b1;
            default: claim_n = 1'b0;
         endcase
      end
      allow_n = txn_master && awake && cmd_en[CMD_BM];
      abort_n = !txn_master && !claim_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_claim <= 1'b0;
         mst_allow <= 1'b0;
         txn_abort <= 1'b0;
      end else if (txn_start) begin
         tgt_claim <= claim_n;
         mst_allow <= allow_n;
         txn_abort <= abort_n;
      end
   end

   AST_LOWPWR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && pm_state != PS_D0 && txn_kind[1] == 1'b0) |=> (!tgt_claim && !mst_allow)); // R8

   AST_CFG_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_start && !txn_master && txn_kind == TK_CFG) |=> tgt_claim); // R9

   AST_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(txn_abort && (tgt_claim || mst_allow))); // R10

   AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_start |=> ($stable(tgt_claim) && $stable(mst_allow) && $stable(txn_abort))); // R11
endmodule

// File: rtl/pm_access_gate.sv
module pm_access_gate
   import pm_gate_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 2,
   parameter logic [7:0]  NEXT_PTR = 8'h50,
   parameter logic [15:0] PMC_VAL  = 16'h0202,
   parameter bit          ALLOW_D2 = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_req,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   input  logic [2:0]    cmd_en,
   input  logic          txn_start,
   input  logic [1:0]    txn_kind,
   input  logic          txn_master,
   output logic          tgt_claim,
   output logic          mst_allow,
   output logic          txn_abort
);
   pstate_e cur_state;

   pm_cap_regs #(
      .DW(DW), .AW(AW), .NEXT_PTR(NEXT_PTR), .PMC_VAL(PMC_VAL), .ALLOW_D2(ALLOW_D2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pm_state(cur_state)
   );

   pm_claim_decide #(.CMD_W(3)) u_decide (
      .clk(clk), .rst_n(rst_n),
      .pm_state(cur_state), .cmd_en(cmd_en),
      .txn_start(txn_start), .txn_kind(txn_kind), .txn_master(txn_master),
      .tgt_claim(tgt_claim), .mst_allow(mst_allow), .txn_abort(txn_abort)
   );
endmodule

// File: tb/pm_access_gate_test.sv
`timescale 1ns/1ps
module pm_access_gate_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_req = 1'b0, cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [2:0]  cmd_en = '0;
   logic        txn_start = 1'b0;
   logic [1:0]  txn_kind = '0;
   logic        txn_master = 1'b0;
   logic        tgt_claim, mst_allow, txn_abort;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pm_access_gate uut (
      .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cmd_en(cmd_en), .txn_start(txn_start), .txn_kind(txn_kind),
      .txn_master(txn_master), .tgt_claim(tgt_claim), .mst_allow(mst_allow),
      .txn_abort(txn_abort)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_req = 0; cfg_we = 0;
   endtask

   task automatic cfg_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = a; cfg_req = 1; cfg_we = 0;
      #1;
      chk(tag, cfg_rdata, exp);
      cfg_req = 0;
   endtask

   // expected {claim, allow, abort}
   function automatic logic [2:0] expect_dec(input logic [1:0] st, input logic [1:0] k,
                                             input logic m, input logic [2:0] c);
      logic on, cl, al;
      on = (st == 2'b00);
      cl = 0;
      if (!m) begin
         if (k == 2'b00) cl = on & c[0];
         else if (k == 2'b01) cl = on & c[1];
         else if (k == 2'b10) cl = 1;
      end
      al = m & on & c[2];
      return {cl, al, (!m & !cl)};
   endfunction

   task automatic run_txn(input logic [1:0] k, input logic m, input logic [2:0] c,
                          input logic [2:0] exp, input string tag);
      @(negedge clk);
      txn_start = 1; txn_kind = k; txn_master = m; cmd_en = c;
      @(negedge clk);
      txn_start = 0;
      #1;
      chk(tag, {29'd0, tgt_claim, mst_allow, txn_abort}, {29'd0, exp});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [1:0] states [3];
      states[0] = 2'b00; states[1] = 2'b01; states[2] = 2'b11;

      // R6: reset state
      #12;
      chk("R6 reset outputs", {29'd0, tgt_claim, mst_allow, txn_abort}, 32'd0);
      cfg_addr = 2'd1; #1;
      chk("R6 reset state D0", cfg_rdata, 32'h0);
      @(negedge clk); rst_n = 1;

      // R1, R2: read-only words
      cfg_read(2'd0, 32'h0202_5001, "R1 header dword");
      cfg_read(2'd1, 32'h0000_0000, "R2 control dword D0");
      cfg_read(2'd2, 32'h0, "R2 dword2 zero");
      cfg_read(2'd3, 32'h0, "R2 dword3 zero");

      // sweep supported states
      foreach (states[i]) begin
         cfg_write(2'd1, {30'h3FFF_FFFF, states[i]});
         cfg_read(2'd1, {30'd0, states[i]}, "R3 state readback");
         cfg_read(2'd1 ^ 2'd1, 32'h0202_5001, "R1 header stable");
         // R4: D2 request ignored
         cfg_write(2'd1, 32'h0000_0002);
         cfg_read(2'd1, {30'd0, states[i]}, "R4 D2 ignored");
         // R5: writes elsewhere ignored
         for (int a = 0; a < 4; a++) begin
            if (a != 1) begin
               cfg_write(a[1:0], 32'hFFFF_FFFE);
               cfg_read(2'd1, {30'd0, states[i]}, "R5 state unchanged");
               cfg_read(2'd0, 32'h0202_5001, "R5 header unchanged");
            end
         end
         // R7..R10: full sweep
         for (int c = 0; c < 8; c++)
            for (int k = 0; k < 4; k++)
               for (int m = 0; m < 2; m++)
                  run_txn(k[1:0], m[0], c[2:0], expect_dec(states[i], k[1:0], m[0], c[2:0]),
                          states[i] == 2'b00 ? "R7 R9 R10 D0 decision" : "R8 R9 R10 low-power decision");
      end

      // R11: same-edge write uses old state
      cfg_write(2'd1, 32'h0);
      @(negedge clk);
      txn_start = 1; txn_kind = 2'b00; txn_master = 0; cmd_en = 3'b111;
      cfg_req = 1; cfg_we = 1; cfg_addr = 2'd1; cfg_wdata = 32'h1;
      @(negedge clk);
      txn_start = 0; cfg_req = 0; cfg_we = 0;
      #1;
      chk("R11 same-edge old state", {29'd0, tgt_claim, mst_allow, txn_abort}, 32'b100);
      run_txn(2'b00, 1'b0, 3'b111, 3'b001, "R11 next txn new state");
      cfg_write(2'd1, 32'h0);
      #1;
      chk("R11 held without start", {29'd0, tgt_claim, mst_allow, txn_abort}, 32'b001);

      // R6: power removal from D3hot returns to D0
      cfg_write(2'd1, 32'h3);
      cfg_read(2'd1, 32'h3, "R3 D3hot");
      @(negedge clk); rst_n = 0; #1;
      chk("R6 outputs after power loss", {29'd0, tgt_claim, mst_allow, txn_abort}, 32'd0);
      @(negedge clk); rst_n = 1;
      cfg_read(2'd1, 32'h0, "R6 state D0 after power loss");
      run_txn(2'b01, 1'b0, 3'b010, 3'b100, "R7 IO claimed after restore");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule